// File: doc/BRIEF.md
# Accumulator Add Execution Unit

This block is the add slice of a small 8-bit accumulator machine. It takes 16-bit instruction words and carries out two of them: adding an 8-bit immediate to the working register W, and adding W to a byte of banked data memory. Every instruction occupies one instruction cycle of four clock phases: decode, operand read, compute and write-back. A five-bit status register records the negative, overflow, zero, digit-carry and carry results of the last add.

The data memory is a register array of `2**BANK_W` banks of 256 bytes. Its address is the concatenation of a bank number and the 8-bit register field. The bank comes either from a fixed access-bank window or from a bank-select register that the surrounding core loads through `bsr_we`/`bsr_d`. A word that is neither instruction produces a one-cycle illegal pulse and leaves all state alone. Fetch logic drives a word with `instr_valid` whenever `phase_o` reads 0; with `instr_valid` low that slot is idle.

Top module: `acc_add_unit`

## Requirements
- R1: `phase_o` steps 0,1,2,3,0 one clock at a time. The word is taken on the clock edge at which `phase_o` is 0, and W and status change only on the fourth edge after that, so they stay unchanged while `phase_o` is 1, 2 or 3.
- R2: A word whose high byte is 0x0F adds its low byte to W and puts the sum in W.
- R3: A word whose top six bits are 001001 adds W to the data byte selected by bit 8 and the low byte. When bit 9 is 0, the sum goes to W and memory is unchanged.
- R4: For the word of R3 with bit 9 set to 1, the sum is written to the selected data byte and W is unchanged.
- R5: With bit 8 clear, register fields 0x00–0x5F address bank 0 and fields 0x60–0xFF address the highest bank.
- R6: With bit 8 set, the bank is the bank-select register, which is loaded from `bsr_d` on any clock edge where `bsr_we` is high.
- R7: Status bit 0 (carry) is the carry out of bit 7 of the add, and status bit 1 (digit carry) is the carry out of bit 3.
- R8: Status bit 2 (zero) is set when the 8-bit sum is zero, and status bit 4 (negative) equals bit 7 of the sum.
- R9: Status bit 3 (overflow) is set when both addends have the same sign bit and the sum's sign bit differs from it.
- R10: Any other valid word raises `illegal_o` for exactly the one clock during which `phase_o` is 1. It changes neither W, nor status, nor memory.
- R11: When `instr_valid` is low at phase 0, the slot changes no state and raises no illegal pulse.
- R12: Reset (`rst_n` low) clears W, status, the bank-select register and all data bytes, and returns `phase_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | A word is offered in this phase-0 slot |
| instr | input | 16 | Instruction word |
| bsr_we | input | 1 | Load the bank-select register |
| bsr_d | input | BANK_W | New bank-select value |
| w_o | output | 8 | Working register W |
| status_o | output | 5 | {N, OV, Z, DC, C} |
| phase_o | output | 2 | Current phase, 0 = decode |
| illegal_o | output | 1 | One-clock pulse for an unsupported word |

## Verification
A phase counter that slips shows up as a misplaced illegal pulse within one clock. It also shows up as W changing at some phase other than 0. A wrong bank or access-window mapping stays hidden until the byte is read back through an add to W: the mismatch then appears on `w_o` four clocks after that read is issued. Flag errors appear on `status_o` at the same phase-0 boundary as the sum, so each add exposes them within one instruction cycle.

// File: rtl/acc_pkg.sv
// Shared types for the accumulator add unit.
// Assumes a status word ordered {N, OV, Z, DC, C} from MSB to LSB.
package acc_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_LIT  = 2'd1,
        OP_WF   = 2'd2,
        OP_BAD  = 2'd3
    } op_e;

    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic dc;
        logic c;
    } flags_t;
endpackage

// File: rtl/acc_decoder.sv
// Instruction decoder: classifies a 16-bit word and splits out its fields.
// Assumes the caller qualifies the result with its own valid signal.
module acc_decoder
    import acc_pkg::*;
(
    input  logic [15:0] word_i,
    output op_e         op_o,
    output logic        dst_mem_o,
    output logic        use_bank_o,
    output logic [7:0]  field_o
);
    // Purpose: match the two supported opcode patterns.
    always_comb begin
        if (word_i[15:8] == 8'h0F)
            op_o = OP_LIT;
        else if (word_i[15:10] == 6'b001001)
            op_o = OP_WF;
        else
            op_o = OP_BAD;
        dst_mem_o  = word_i[9];
        use_bank_o = word_i[8];
        field_o    = word_i[7:0];
    end
endmodule

// File: rtl/acc_addr_map.sv
// Data address former: picks the bank from the access window or the
// bank-select register and joins it to the 8-bit register field.
// Assumes the access window's upper region maps to the highest bank.
module acc_addr_map #(
    parameter int         BANK_W = 2,
    parameter logic [7:0] SPLIT  = 8'h60,
    localparam int        AW     = BANK_W + 8
) (
    input  logic              use_bank_i,
    input  logic [7:0]        field_i,
    input  logic [BANK_W-1:0] bsr_i,
    output logic [AW-1:0]     addr_o
);
    logic [BANK_W-1:0] bank;

    // Purpose: choose the bank for this access.
    always_comb begin
        if (use_bank_i)
            bank = bsr_i;
        else if (field_i < SPLIT)
            bank = '0;
        else
            bank = '1;
        addr_o = {bank, field_i};
    end
endmodule

// File: rtl/acc_alu.sv
// 8-bit adder with status generation.
// Assumes unsigned carries and two's-complement overflow.
module acc_alu
    import acc_pkg::*;
(
    input  logic [7:0] a_i,
    input  logic [7:0] b_i,
    output logic [7:0] sum_o,
    output flags_t     flg_o
);
    logic [8:0] full;
    logic [4:0] low;

    // Purpose: form the sum and its five flags.
    always_comb begin
        full      = {1'b0, a_i} + {1'b0, b_i};
        low       = {1'b0, a_i[3:0]} + {1'b0, b_i[3:0]};
        sum_o     = full[7:0];
        flg_o.c   = full[8];
        flg_o.dc  = low[4];
        flg_o.z   = (full[7:0] == 8'h00);
        flg_o.n   = full[7];
        flg_o.ov  = (a_i[7] == b_i[7]) && (full[7] != a_i[7]);
    end
endmodule

// File: rtl/acc_regfile.sv
// Banked data memory: asynchronous read, synchronous write, cleared on reset.
// Assumes one write per clock at most.
module acc_regfile #(
    parameter  int BANK_W = 2,
    localparam int AW     = BANK_W + 8,
    localparam int DEPTH  = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    wdata_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] mem [DEPTH];

    // Purpose: clear on reset, otherwise store the write-back byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= 8'h00;
        end else if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
    end

    // Purpose: combinational operand read.
    assign rdata_o = mem[addr_i];
endmodule

// File: rtl/acc_add_unit.sv
// Four-phase add execution unit for an 8-bit accumulator machine.
// Phase 0 decodes, 1 fetches the operand, 2 adds, 3 writes back.
// Assumes the word and instr_valid are held stable around the phase-0 edge.
module acc_add_unit
    import acc_pkg::*;
#(
    parameter int BANK_W = 2,
    localparam int AW    = BANK_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr,
    input  logic              bsr_we,
    input  logic [BANK_W-1:0] bsr_d,
    output logic [7:0]        w_o,
    output logic [4:0]        status_o,
    output logic [1:0]        phase_o,
    output logic              illegal_o
);
    logic [1:0]        ph;
    op_e               dec_op, op_q;
    logic              dec_dst, dec_bank, dst_q;
    logic [7:0]        dec_field, lit_q, opnd_q, res_q, w_q, mem_rd, alu_sum;
    logic [AW-1:0]     map_addr, addr_q;
    logic [BANK_W-1:0] bsr_q;
    flags_t            alu_flg, flg_q, st_q;
    logic              ill_q, mem_we;

    acc_decoder u_dec (
        .word_i     (instr),
        .op_o       (dec_op),
        .dst_mem_o  (dec_dst),
        .use_bank_o (dec_bank),
        .field_o    (dec_field)
    );

    acc_addr_map #(.BANK_W(BANK_W)) u_map (
        .use_bank_i (dec_bank),
        .field_i    (dec_field),
        .bsr_i      (bsr_q),
        .addr_o     (map_addr)
    );

    acc_alu u_alu (
        .a_i   (w_q),
        .b_i   (opnd_q),
        .sum_o (alu_sum),
        .flg_o (alu_flg)
    );

    assign mem_we = (ph == 2'd3) && (op_q == OP_WF) && dst_q;

    acc_regfile #(.BANK_W(BANK_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .addr_i  (addr_q),
        .wdata_i (res_q),
        .rdata_o (mem_rd)
    );

    // Purpose: free-running phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= 2'd0;
        else        ph <= ph + 2'd1;
    end

    // Purpose: bank-select register load.
    always_ff @(posedge clk) begin
        if (!rst_n)      bsr_q <= '0;
        else if (bsr_we) bsr_q <= bsr_d;
    end

    // Purpose: decode-phase capture and illegal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            dst_q  <= 1'b0;
            addr_q <= '0;
            lit_q  <= 8'h00;
            ill_q  <= 1'b0;
        end else if (ph == 2'd0) begin
            op_q   <= instr_valid ? dec_op : OP_IDLE;
            dst_q  <= dec_dst;
            addr_q <= map_addr;
            lit_q  <= dec_field;
            ill_q  <= instr_valid && (dec_op == OP_BAD);
        end else begin
            ill_q  <= 1'b0;
        end
    end

    // Purpose: operand read in phase 1 and add in phase 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_q <= 8'h00;
            res_q  <= 8'h00;
            flg_q  <= '0;
        end else if (ph == 2'd1) begin
            opnd_q <= (op_q == OP_LIT) ? lit_q : mem_rd;
        end else if (ph == 2'd2) begin
            res_q  <= alu_sum;
            flg_q  <= alu_flg;
        end
    end

    // Purpose: write back W and status in phase 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q  <= 8'h00;
            st_q <= '0;
        end else if (ph == 2'd3) begin
            if (op_q == OP_LIT || (op_q == OP_WF && !dst_q))
                w_q <= res_q;
            if (op_q == OP_LIT || op_q == OP_WF)
                st_q <= flg_q;
        end
    end

    assign w_o       = w_q;
    assign status_o  = st_q;
    assign phase_o   = ph;
    assign illegal_o = ill_q;
endmodule

// File: rtl/acc_add_unit_chk.sv
// Port-level checker for acc_add_unit, attached by bind.
module acc_add_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       instr_valid,
    input logic [7:0] w_o,
    input logic [4:0] status_o,
    input logic [1:0] phase_o,
    input logic       illegal_o
);
    // R1: the phase advances by one each clock
    a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase_o == $past(phase_o) + 2'd1);

    // R1: W only changes on entry to phase 0
    a_r1_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd0) |-> $stable(w_o));

    // R1: status only changes on entry to phase 0
    a_r1_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd0) |-> $stable(status_o));

    // R10: the illegal pulse sits in phase 1
    a_r10_pulse_phase: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> phase_o == 2'd1);

    // R10: the pulse lasts one clock
    a_r10_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> !illegal_o);

    // R10: W survives an illegal word
    a_r10_w_kept: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> ##3 (w_o == $past(w_o, 3)));

    // R11: an idle slot raises no pulse
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd0 && !instr_valid) |=> !illegal_o);
endmodule

bind acc_add_unit acc_add_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .w_o         (w_o),
    .status_o    (status_o),
    .phase_o     (phase_o),
    .illegal_o   (illegal_o)
);

// File: tb/tb_acc_add_unit.sv
`timescale 1ns/1ps
module tb_acc_add_unit;
    localparam int BANK_W = 2;
    localparam int DEPTH  = 1 << (BANK_W + 8);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              instr_valid = 1'b0;
    logic [15:0]       instr = 16'h0000;
    logic              bsr_we = 1'b0;
    logic [BANK_W-1:0] bsr_d = '0;
    logic [7:0]        w_o;
    logic [4:0]        status_o;
    logic [1:0]        phase_o;
    logic              illegal_o;

    int tests = 0;
    int fails = 0;
    logic [7:0]        m_w;
    logic [4:0]        m_st;
    logic [BANK_W-1:0] m_bsr;
    logic [7:0]        m_mem [DEPTH];

    acc_add_unit #(.BANK_W(BANK_W)) dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .bsr_we(bsr_we), .bsr_d(bsr_d), .w_o(w_o), .status_o(status_o),
        .phase_o(phase_o), .illegal_o(illegal_o)
    );

    always #2.5 clk = ~clk;

    // {word, expected W, expected status}, run from W = 0 after reset
    localparam logic [28:0] VEC [7] = '{
        {16'h0F10, 8'h10, 5'b00000},
        {16'h0F15, 8'h25, 5'b00000},
        {16'h0FDB, 8'h00, 5'b00111},
        {16'h0F7F, 8'h7F, 5'b00000},
        {16'h0F01, 8'h80, 5'b11010},
        {16'h0F80, 8'h00, 5'b01101},
        {16'h0F17, 8'h17, 5'b00000}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [12:0] ref_add(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        logic c, dc, z, n, ov;
        s  = {1'b0, a} + {1'b0, b};
        c  = s[8];
        dc = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
        z  = s[7:0] == 8'h00;
        n  = s[7];
        ov = (a[7] == b[7]) && (s[7] != a[7]);
        return {n, ov, z, dc, c, s[7:0]};
    endfunction

    function automatic int ref_addr(input logic abit, input logic [7:0] f);
        if (abit) return {m_bsr, f};
        if (f < 8'h60) return {{BANK_W{1'b0}}, f};
        return {{BANK_W{1'b1}}, f};
    endfunction

    task automatic model_reset();
        m_w = 8'h00; m_st = 5'h00; m_bsr = '0;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
    endtask

    // Issue one slot at phase 0 and check W, status and the illegal pulse.
    task automatic run(input logic v, input logic [15:0] word, input string req);
        logic [12:0] r;
        logic exp_il;
        logic il;
        logic [7:0] w_before;
        int ad;
        check(phase_o == 2'd0, "R1 slot start phase", phase_o, 0);
        w_before = w_o;
        instr_valid = v;
        instr = word;
        @(negedge clk);
        il = illegal_o;
        instr_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (w_o != w_before) check(1'b0, "R1 W early change", w_o, w_before);
        @(negedge clk);
        exp_il = 1'b0;
        if (v) begin
            if (word[15:8] == 8'h0F) begin
                r = ref_add(m_w, word[7:0]);
                m_w = r[7:0]; m_st = r[12:8];
            end else if (word[15:10] == 6'b001001) begin
                ad = ref_addr(word[8], word[7:0]);
                r = ref_add(m_w, m_mem[ad]);
                m_st = r[12:8];
                if (word[9]) m_mem[ad] = r[7:0];
                else m_w = r[7:0];
            end else begin
                exp_il = 1'b1;
            end
        end
        check(w_o == m_w, req, w_o, m_w);
        check(status_o == m_st, req, status_o, m_st);
        check(il == exp_il, req, il, exp_il);
    endtask

    task automatic set_w(input logic [7:0] v);
        run(1'b1, {8'h0F, v - m_w}, "R2 set W");
    endtask

    task automatic load_bsr(input logic [BANK_W-1:0] b);
        bsr_d = b; bsr_we = 1'b1;
        @(negedge clk);
        bsr_we = 1'b0;
        m_bsr = b;
        while (phase_o != 2'd0) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    bit done = 0;
    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();
        // R12: reset state
        check(w_o == 8'h00, "R12 W after reset", w_o, 0);
        check(status_o == 5'h00, "R12 status after reset", status_o, 0);
        check(phase_o == 2'd0, "R12 phase after reset", phase_o, 0);
        check(illegal_o == 1'b0, "R12 no pulse after reset", illegal_o, 0);

        // R2 R7 R8 R9: literal add table
        foreach (VEC[i]) begin
            run(1'b1, VEC[i][28:13], "R2 literal vector");
            check(w_o == VEC[i][12:5], "R2 table W", w_o, VEC[i][12:5]);
            check(status_o == VEC[i][4:0], "R7 R8 R9 table status", status_o, VEC[i][4:0]);
        end

        // R1: phase walk
        for (int k = 0; k < 4; k++) begin
            check(phase_o == 2'(k), "R1 phase walk", phase_o, k);
            @(negedge clk);
        end

        // R3: W + memory into W, memory kept
        set_w(8'hC2);
        run(1'b1, 16'h2620, "R4 store C2");
        set_w(8'h17);
        run(1'b1, 16'h2420, "R3 add to W");
        check(w_o == 8'hD9, "R3 example sum", w_o, 8'hD9);
        set_w(8'h00);
        run(1'b1, 16'h2420, "R3 readback");
        check(w_o == 8'hC2, "R3 memory kept", w_o, 8'hC2);

        // R4: result to memory, W unchanged
        set_w(8'h05);
        run(1'b1, 16'h2621, "R4 store");
        run(1'b1, 16'h2621, "R4 store again");
        check(w_o == 8'h05, "R4 W unchanged", w_o, 8'h05);
        set_w(8'h00);
        run(1'b1, 16'h2421, "R4 readback");
        check(w_o == 8'h0A, "R4 memory sum", w_o, 8'h0A);

        // R5 R6: access window vs bank register
        set_w(8'h3C);
        run(1'b1, 16'h2670, "R5 upper window store");
        set_w(8'h00);
        load_bsr(2'd3);
        run(1'b1, 16'h2570, "R6 banked read of top bank");
        check(w_o == 8'h3C, "R5 upper window is top bank", w_o, 8'h3C);
        set_w(8'h00);
        load_bsr(2'd1);
        run(1'b1, 16'h2520, "R6 bank 1 empty");
        check(w_o == 8'h00, "R6 bank 1 separate", w_o, 8'h00);
        load_bsr(2'd0);
        run(1'b1, 16'h2520, "R5 bank 0 via register");
        check(w_o == 8'hC2, "R5 lower window is bank 0", w_o, 8'hC2);

        // R10: unsupported words
        run(1'b1, 16'hFFFF, "R10 all ones");
        run(1'b1, 16'h0E12, "R10 near literal");
        run(1'b1, 16'h2A21, "R10 near register add");
        set_w(8'h00);
        run(1'b1, 16'h2421, "R10 memory kept");
        check(w_o == 8'h0A, "R10 memory untouched", w_o, 8'h0A);

        // R11: idle slot
        run(1'b0, 16'h0F55, "R11 idle slot");
        check(w_o == 8'h0A, "R11 W kept", w_o, 8'h0A);

        // R12: reset clears bank register and memory
        load_bsr(2'd2);
        do_reset();
        check(w_o == 8'h00 && status_o == 5'h00, "R12 second reset", w_o, 0);
        run(1'b1, 16'h2421, "R12 memory cleared");
        set_w(8'h33);
        run(1'b1, 16'h2620, "R12 store bank 0");
        set_w(8'h00);
        run(1'b1, 16'h2520, "R12 bank register cleared");
        check(w_o == 8'h33, "R12 bank register is 0", w_o, 8'h33);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule